// File: doc/BRIEF.md
# Dirty Victim Writeback Engine

This block sits beside a last-level cache array. It takes over a line after the replacement logic has picked it for eviction. A clean line (exclusive or shared) only needs an invalidate pulse toward the array. A dirty line (modified or owned) follows a longer path:

- Its address, data and dirty bit are copied into a one-line holding buffer.
- The array is told to invalidate the line.
- A dirty-victim control request goes to the directory.
- The engine then waits for memory to acknowledge the writeback, and on that acknowledge it sends the held data.

While the writeback is outstanding, the buffer is the only copy of the line, so the engine answers coherence probes for that address from the buffer:

- A downgrade probe is answered with the held data, and the line is remembered as shared.
- An invalidating probe is answered and turns the writeback into a cancel request. The engine then waits in a cancelled state until the memory acknowledge arrives, and sends no data.

Requests for the held line that arrive while the engine is busy are handled as follows:

- Reads are forwarded to the directory.
- New victim requests are sent back for a later retry.

A second eviction is held off through a ready signal until the buffer is free. At most one event (eviction, acknowledge, probe or request) is presented per cycle. Every message leaves one clock after the event that causes it.

Top module: `evict_wb_engine`

## Requirements
- R1: An eviction accepted while `evict_ready` is high, with `evict_state` 3 (modified) or 2 (owned), produces one cycle later a line invalidate and a dirty-victim request, both carrying the evicted address. `evict_ready` is low from that cycle onward.
- R2: An accepted eviction with `evict_state` 0 (shared) or 1 (exclusive) produces one cycle later a line invalidate only. No dirty-victim request is sent, and `evict_ready` stays high.
- R3: `evict_ready` is high after reset, and no output valid is set. While the engine is busy, `evict_ready` is low and an eviction request has no effect (no invalidate, no victim request).
- R4: A memory acknowledge while a writeback is pending produces one cycle later `wb_valid`, carrying the held address, data, dirty bit and shared flag. The engine is then idle and `evict_ready` is high in that same cycle.
- R5: A downgrade probe (`probe_inv`=0) whose address matches a pending writeback is answered one cycle later with kind 3 (data) and the held data. The writeback stays pending, and its later `wb_shared` is 1.
- R6: An invalidating probe (`probe_inv`=1) whose address matches a pending writeback is answered one cycle later with kind 3 (data) if `probe_want_data` is 1, otherwise with kind 2 (invalidate ack). In that same cycle a cancel request carries the held address, and the engine enters the cancelled state.
- R7: In the cancelled state, a matching invalidating probe gets kind 2 and a matching downgrade probe gets kind 1 (miss). A memory acknowledge returns the engine to idle with no writeback data.
- R8: While busy, a request whose address matches the held line is handled one cycle later: a read (`req_victim`=0) is forwarded with its address, and a victim request (`req_victim`=1) raises `req_retry`.
- R9: Probes and requests that do not match the held address, or that arrive while the engine is idle, produce no response, forward or retry.
- R10: A memory acknowledge while the engine is idle produces no writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evict_valid | input | 1 | Eviction request for a chosen line |
| evict_state | input | 2 | Line state: 0 shared, 1 exclusive, 2 owned, 3 modified |
| evict_addr | input | AW | Line address |
| evict_data | input | DW | Line data |
| evict_dirty | input | 1 | Line dirty bit |
| evict_ready | output | 1 | Engine can accept an eviction |
| mem_ack | input | 1 | Memory writeback acknowledge |
| probe_valid | input | 1 | Coherence probe |
| probe_inv | input | 1 | 1 invalidating, 0 downgrade |
| probe_want_data | input | 1 | Probe asks for data |
| probe_addr | input | AW | Probe address |
| req_valid | input | 1 | Incoming request for a line |
| req_victim | input | 1 | 1 victim request, 0 read |
| req_addr | input | AW | Request address |
| line_inval_valid | output | 1 | Invalidate the line in the array |
| line_inval_addr | output | AW | Address to invalidate |
| vic_req_valid | output | 1 | Dirty-victim request to directory |
| vic_req_addr | output | AW | Victim address |
| wb_valid | output | 1 | Writeback data message |
| wb_addr | output | AW | Writeback address |
| wb_data | output | DW | Writeback data |
| wb_dirty | output | 1 | Writeback dirty flag |
| wb_shared | output | 1 | Line was downgraded while pending |
| prb_rsp_valid | output | 1 | Probe response |
| prb_rsp_kind | output | 2 | 1 miss, 2 invalidate ack, 3 data |
| prb_rsp_data | output | DW | Data for kind 3 |
| cancel_valid | output | 1 | Writeback cancel to directory |
| cancel_addr | output | AW | Cancelled address |
| fwd_valid | output | 1 | Read forwarded to directory |
| fwd_addr | output | AW | Forwarded address |
| req_retry | output | 1 | Victim request must be retried |

## Verification
Every message output (invalidate, victim request, writeback, probe response, cancel, forward, retry) is due exactly one clock after the rising edge that samples its stimulus. `evict_ready` follows the engine state in that same cycle. The bench applies each event at a falling edge, samples all outputs at the next falling edge and then clears the event, so each comparison falls in the single cycle in which the result is valid. Data fields are compared only when their valid, or data kind, is set.

// File: rtl/evict_pkg.sv
package evict_pkg;

    typedef enum logic [1:0] {
        LS_SHARED = 2'd0,
        LS_EXCL   = 2'd1,
        LS_OWNED  = 2'd2,
        LS_MOD    = 2'd3
    } line_st_t;

    typedef enum logic [1:0] {
        EV_IDLE = 2'd0,
        EV_PEND = 2'd1,
        EV_CANC = 2'd2
    } ev_st_t;

    typedef enum logic [1:0] {
        PR_NONE    = 2'd0,
        PR_MISS    = 2'd1,
        PR_INV_ACK = 2'd2,
        PR_DATA    = 2'd3
    } prb_rsp_t;

    typedef struct packed {
        logic     inval;
        logic     capture;
        logic     send_vic;
        logic     send_wb;
        logic     send_cancel;
        logic     set_shared;
        logic     fwd;
        logic     retry;
        prb_rsp_t prb;
    } ev_act_t;

    function automatic logic line_is_dirty(line_st_t s);
        return (s == LS_OWNED) || (s == LS_MOD);
    endfunction

endpackage

// File: rtl/evict_buf.sv
module evict_buf
    import evict_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          capture,
    input  logic          set_shared,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_data,
    input  logic          in_dirty,
    input  logic [AW-1:0] probe_addr,
    input  logic [AW-1:0] req_addr,
    output logic [AW-1:0] held_addr,
    output logic [DW-1:0] held_data,
    output logic          held_dirty,
    output logic          held_shared,
    output logic          probe_match,
    output logic          req_match
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held_addr   <= '0;
            held_data   <= '0;
            held_dirty  <= 1'b0;
            held_shared <= 1'b0;
        end else if (capture) begin
            held_addr   <= in_addr;
            held_data   <= in_data;
            held_dirty  <= in_dirty;
            held_shared <= 1'b0;
        end else if (set_shared) begin
            held_shared <= 1'b1;
        end
    end

    assign probe_match = (probe_addr == held_addr);
    assign req_match   = (req_addr == held_addr);
endmodule

// File: rtl/evict_ctrl.sv
module evict_ctrl
    import evict_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     evict_valid,
    input  line_st_t evict_state,
    input  logic     mem_ack,
    input  logic     probe_valid,
    input  logic     probe_inv,
    input  logic     probe_want_data,
    input  logic     probe_match,
    input  logic     req_valid,
    input  logic     req_victim,
    input  logic     req_match,
    output ev_st_t   st,
    output ev_act_t  act
);
    ev_st_t st_nxt;
    logic   busy;

    assign busy = (st != EV_IDLE);

    always_comb begin
        st_nxt = st;
        act    = '0;
        case (st)
            EV_IDLE: begin
                if (evict_valid) begin
                    act.inval = 1'b1;
                    if (line_is_dirty(evict_state)) begin
                        act.capture  = 1'b1;
                        act.send_vic = 1'b1;
                        st_nxt       = EV_PEND;
                    end
                end
            end
            EV_PEND: begin
                if (mem_ack) begin
                    act.send_wb = 1'b1;
                    st_nxt      = EV_IDLE;
                end else if (probe_valid && probe_match) begin
                    if (!probe_inv) begin
                        act.prb        = PR_DATA;
                        act.set_shared = 1'b1;
                    end else begin
                        act.prb         = probe_want_data ? PR_DATA : PR_INV_ACK;
                        act.send_cancel = 1'b1;
                        st_nxt          = EV_CANC;
                    end
                end
            end
            EV_CANC: begin
                if (mem_ack) begin
                    st_nxt = EV_IDLE;
                end else if (probe_valid && probe_match) begin
                    act.prb = probe_inv ? PR_INV_ACK : PR_MISS;
                end
            end
            default: st_nxt = EV_IDLE;
        endcase
        if (busy && req_valid && req_match) begin
            act.retry = req_victim;
            act.fwd   = !req_victim;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= EV_IDLE;
        else     st <= st_nxt;
    end
endmodule

// File: rtl/evict_wb_engine.sv
module evict_wb_engine
    import evict_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          evict_valid,
    input  logic [1:0]    evict_state,
    input  logic [AW-1:0] evict_addr,
    input  logic [DW-1:0] evict_data,
    input  logic          evict_dirty,
    output logic          evict_ready,
    input  logic          mem_ack,
    input  logic          probe_valid,
    input  logic          probe_inv,
    input  logic          probe_want_data,
    input  logic [AW-1:0] probe_addr,
    input  logic          req_valid,
    input  logic          req_victim,
    input  logic [AW-1:0] req_addr,
    output logic          line_inval_valid,
    output logic [AW-1:0] line_inval_addr,
    output logic          vic_req_valid,
    output logic [AW-1:0] vic_req_addr,
    output logic          wb_valid,
    output logic [AW-1:0] wb_addr,
    output logic [DW-1:0] wb_data,
    output logic          wb_dirty,
    output logic          wb_shared,
    output logic          prb_rsp_valid,
    output logic [1:0]    prb_rsp_kind,
    output logic [DW-1:0] prb_rsp_data,
    output logic          cancel_valid,
    output logic [AW-1:0] cancel_addr,
    output logic          fwd_valid,
    output logic [AW-1:0] fwd_addr,
    output logic          req_retry
);
    ev_st_t        st_q;
    ev_act_t       act;
    logic [AW-1:0] held_addr;
    logic [DW-1:0] held_data;
    logic          held_dirty, held_shared, probe_match, req_match;
    logic          evict_go;

    assign evict_ready = (st_q == EV_IDLE);
    assign evict_go    = evict_valid && evict_ready;

    evict_buf #(.AW(AW), .DW(DW)) u_buf (
        .clk(clk), .rst(rst),
        .capture(act.capture), .set_shared(act.set_shared),
        .in_addr(evict_addr), .in_data(evict_data), .in_dirty(evict_dirty),
        .probe_addr(probe_addr), .req_addr(req_addr),
        .held_addr(held_addr), .held_data(held_data),
        .held_dirty(held_dirty), .held_shared(held_shared),
        .probe_match(probe_match), .req_match(req_match)
    );

    evict_ctrl u_ctrl (
        .clk(clk), .rst(rst),
        .evict_valid(evict_go), .evict_state(line_st_t'(evict_state)),
        .mem_ack(mem_ack),
        .probe_valid(probe_valid), .probe_inv(probe_inv),
        .probe_want_data(probe_want_data), .probe_match(probe_match),
        .req_valid(req_valid), .req_victim(req_victim), .req_match(req_match),
        .st(st_q), .act(act)
    );

    // one-cycle message stage toward directory and array
    always_ff @(posedge clk) begin
        if (rst) begin
            line_inval_valid <= 1'b0;
            vic_req_valid    <= 1'b0;
            wb_valid         <= 1'b0;
            prb_rsp_valid    <= 1'b0;
            prb_rsp_kind     <= PR_NONE;
            cancel_valid     <= 1'b0;
            fwd_valid        <= 1'b0;
            req_retry        <= 1'b0;
            line_inval_addr  <= '0;
            vic_req_addr     <= '0;
            wb_addr          <= '0;
            wb_data          <= '0;
            wb_dirty         <= 1'b0;
            wb_shared        <= 1'b0;
            prb_rsp_data     <= '0;
            cancel_addr      <= '0;
            fwd_addr         <= '0;
        end else begin
            line_inval_valid <= act.inval;
            vic_req_valid    <= act.send_vic;
            wb_valid         <= act.send_wb;
            prb_rsp_valid    <= (act.prb != PR_NONE);
            prb_rsp_kind     <= act.prb;
            cancel_valid     <= act.send_cancel;
            fwd_valid        <= act.fwd;
            req_retry        <= act.retry;
            line_inval_addr  <= evict_addr;
            vic_req_addr     <= evict_addr;
            wb_addr          <= held_addr;
            wb_data          <= held_data;
            wb_dirty         <= held_dirty;
            wb_shared        <= held_shared;
            prb_rsp_data     <= held_data;
            cancel_addr      <= held_addr;
            fwd_addr         <= req_addr;
        end
    end
endmodule

// File: rtl/evict_wb_chk.sv
module evict_wb_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          evict_valid,
    input logic [1:0]    evict_state,
    input logic [AW-1:0] evict_addr,
    input logic          evict_ready,
    input logic          mem_ack,
    input logic          line_inval_valid,
    input logic          vic_req_valid,
    input logic [AW-1:0] vic_req_addr,
    input logic          wb_valid,
    input logic          prb_rsp_valid,
    input logic [1:0]    prb_rsp_kind,
    input logic          cancel_valid,
    input logic          fwd_valid,
    input logic          req_retry
);
    assert_dirty_evict_R1: assert property (@(posedge clk) disable iff (rst)
        (evict_valid && evict_ready && evict_state[1]) |=>
        (vic_req_valid && line_inval_valid && vic_req_addr == $past(evict_addr) && !evict_ready));

    assert_clean_evict_R2: assert property (@(posedge clk) disable iff (rst)
        (evict_valid && evict_ready && !evict_state[1]) |=>
        (line_inval_valid && !vic_req_valid && evict_ready));

    assert_busy_ignore_R3: assert property (@(posedge clk) disable iff (rst)
        (evict_valid && !evict_ready) |=> (!line_inval_valid && !vic_req_valid));

    assert_wb_frees_R4: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> evict_ready);

    assert_cancel_has_rsp_R6: assert property (@(posedge clk) disable iff (rst)
        cancel_valid |-> (prb_rsp_valid && prb_rsp_kind != 2'd1 && !wb_valid));

    assert_req_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        !(req_retry && fwd_valid));

    assert_idle_ack_R10: assert property (@(posedge clk) disable iff (rst)
        (mem_ack && evict_ready) |=> !wb_valid);

    assert_dir_msgs_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0({vic_req_valid, wb_valid, cancel_valid}));
endmodule

bind evict_wb_engine evict_wb_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst), .evict_valid(evict_valid), .evict_state(evict_state),
    .evict_addr(evict_addr), .evict_ready(evict_ready), .mem_ack(mem_ack),
    .line_inval_valid(line_inval_valid), .vic_req_valid(vic_req_valid),
    .vic_req_addr(vic_req_addr), .wb_valid(wb_valid), .prb_rsp_valid(prb_rsp_valid),
    .prb_rsp_kind(prb_rsp_kind), .cancel_valid(cancel_valid), .fwd_valid(fwd_valid),
    .req_retry(req_retry)
);

// File: tb/tb_evict_wb_engine.sv
`timescale 1ns/100ps
module tb_evict_wb_engine;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int EV_NONE = 0, EV_EVICT = 1, EV_ACK = 2, EV_PRB = 3, EV_REQ = 4;
    localparam int OW = 1 + 4*AW + 1 + AW + 1 + DW + 2 + 1 + 2 + DW + 1 + 1 + 1 + 1;

    logic clk = 1'b0, rst = 1'b1;
    always #2.5 clk = ~clk;

    logic          evict_valid = 0, evict_dirty = 0, mem_ack = 0;
    logic [1:0]    evict_state = 0;
    logic [AW-1:0] evict_addr = 0, probe_addr = 0, req_addr = 0;
    logic [DW-1:0] evict_data = 0;
    logic          probe_valid = 0, probe_inv = 0, probe_want_data = 0;
    logic          req_valid = 0, req_victim = 0;
    logic          evict_ready, line_inval_valid, vic_req_valid, wb_valid, wb_dirty, wb_shared;
    logic          prb_rsp_valid, cancel_valid, fwd_valid, req_retry;
    logic [1:0]    prb_rsp_kind;
    logic [AW-1:0] line_inval_addr, vic_req_addr, wb_addr, cancel_addr, fwd_addr;
    logic [DW-1:0] wb_data, prb_rsp_data;

    evict_wb_engine #(.AW(AW), .DW(DW)) dut (.*);

    int errors = 0, checks = 0;
    bit done = 0;

    // bench model: 0 idle, 1 pending, 2 cancelled
    int            m_st = 0;
    logic [AW-1:0] m_addr = 0;
    logic [DW-1:0] m_data = 0;
    logic          m_dirty = 0, m_shared = 0;

    function automatic logic [OW-1:0] pack_out(
        input logic iv, input logic [AW-1:0] ia, input logic vv, input logic [AW-1:0] va,
        input logic wv, input logic [AW-1:0] wa, input logic [DW-1:0] wd, input logic wdi,
        input logic ws, input logic pv, input logic [1:0] pk, input logic [DW-1:0] pd,
        input logic cv, input logic [AW-1:0] ca, input logic fv, input logic [AW-1:0] fa,
        input logic rr, input logic rdy);
        return {iv, iv ? ia : '0, vv, vv ? va : '0, wv, wv ? wa : '0, wv ? wd : '0,
                wv & wdi, wv & ws, pv, pv ? pk : 2'd0, (pv && pk == 2'd3) ? pd : '0,
                cv, cv ? ca : '0, fv, fv ? fa : '0, rr, rdy};
    endfunction

    task automatic step(input int ev, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [1:0] ls, input logic dty, input logic inv,
                        input logic want, input logic vict);
        logic iv = 0, vv = 0, wv = 0, wdi = 0, ws = 0, pv = 0, cv = 0, fv = 0, rr = 0;
        logic [AW-1:0] ia = 0, va = 0, wa = 0, ca = 0, fa = 0;
        logic [DW-1:0] wd = 0, pd = 0;
        logic [1:0] pk = 0;
        logic [OW-1:0] expv, actv;
        string tag;
        tag = "R9";
        case (ev)
            EV_EVICT: begin
                evict_valid = 1; evict_state = ls; evict_addr = a; evict_data = d; evict_dirty = dty;
                if (m_st == 0) begin
                    iv = 1; ia = a;
                    if (ls >= 2'd2) begin
                        tag = "R1"; vv = 1; va = a; m_st = 1;
                        m_addr = a; m_data = d; m_dirty = dty; m_shared = 0;
                    end else tag = "R2";
                end else tag = "R3";
            end
            EV_ACK: begin
                mem_ack = 1;
                if (m_st == 1) begin
                    tag = "R4"; wv = 1; wa = m_addr; wd = m_data; wdi = m_dirty; ws = m_shared; m_st = 0;
                end else if (m_st == 2) begin tag = "R7"; m_st = 0; end
                else tag = "R10";
            end
            EV_PRB: begin
                probe_valid = 1; probe_addr = a; probe_inv = inv; probe_want_data = want;
                if (m_st != 0 && a == m_addr) begin
                    pv = 1; pd = m_data;
                    if (m_st == 1 && !inv) begin tag = "R5"; pk = 2'd3; m_shared = 1; end
                    else if (m_st == 1) begin
                        tag = "R6"; pk = want ? 2'd3 : 2'd2; cv = 1; ca = m_addr; m_st = 2;
                    end else begin tag = "R7"; pk = inv ? 2'd2 : 2'd1; end
                end
            end
            EV_REQ: begin
                req_valid = 1; req_addr = a; req_victim = vict;
                if (m_st != 0 && a == m_addr) begin
                    tag = "R8"; rr = vict; fv = !vict; fa = a;
                end
            end
            default: tag = "R3";
        endcase
        expv = pack_out(iv, ia, vv, va, wv, wa, wd, wdi, ws, pv, pk, pd, cv, ca, fv, fa, rr, m_st == 0);
        @(negedge clk);
        actv = pack_out(line_inval_valid, line_inval_addr, vic_req_valid, vic_req_addr,
                        wb_valid, wb_addr, wb_data, wb_dirty, wb_shared, prb_rsp_valid,
                        prb_rsp_kind, prb_rsp_data, cancel_valid, cancel_addr, fwd_valid,
                        fwd_addr, req_retry, evict_ready);
        checks++;
        if (actv !== expv) begin
            errors++;
            $display("FAIL %s event=%0d actual=%h expected=%h", tag, ev, actv, expv);
        end
        evict_valid = 0; mem_ack = 0; probe_valid = 0; req_valid = 0;
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'h5EED1234);
        repeat (4) @(negedge clk);
        rst = 0;
        step(EV_NONE, 0, 0, 0, 0, 0, 0, 0);                          // R3 reset state
        step(EV_EVICT, 16'h0100, 32'hAAAA0001, 2'd1, 0, 0, 0, 0);    // R2 exclusive
        step(EV_EVICT, 16'h0104, 32'hAAAA0002, 2'd0, 0, 0, 0, 0);    // R2 shared
        step(EV_ACK, 0, 0, 0, 0, 0, 0, 0);                           // R10
        step(EV_EVICT, 16'h0200, 32'hDEAD0001, 2'd3, 1, 0, 0, 0);    // R1 modified
        step(EV_EVICT, 16'h0300, 32'h11110000, 2'd3, 1, 0, 0, 0);    // R3 busy
        step(EV_PRB, 16'h0204, 0, 0, 0, 1, 0, 0);                    // R9 mismatch
        step(EV_REQ, 16'h0200, 0, 0, 0, 0, 0, 0);                    // R8 forward
        step(EV_REQ, 16'h0200, 0, 0, 0, 0, 0, 1);                    // R8 retry
        step(EV_PRB, 16'h0200, 0, 0, 0, 0, 1, 0);                    // R5 downgrade
        step(EV_ACK, 0, 0, 0, 0, 0, 0, 0);                           // R4 shared=1
        step(EV_EVICT, 16'h0400, 32'hBEEF0002, 2'd2, 0, 0, 0, 0);    // R1 owned
        step(EV_PRB, 16'h0400, 0, 0, 0, 1, 0, 0);                    // R6 inv ack
        step(EV_PRB, 16'h0400, 0, 0, 0, 1, 1, 0);                    // R7 inv ack
        step(EV_PRB, 16'h0400, 0, 0, 0, 0, 1, 0);                    // R7 miss
        step(EV_REQ, 16'h0400, 0, 0, 0, 0, 0, 1);                    // R8 retry cancelled
        step(EV_ACK, 0, 0, 0, 0, 0, 0, 0);                           // R7 back to idle
        step(EV_EVICT, 16'h0500, 32'hCAFE0003, 2'd3, 1, 0, 0, 0);    // R1
        step(EV_PRB, 16'h0500, 0, 0, 0, 1, 1, 0);                    // R6 data
        step(EV_ACK, 0, 0, 0, 0, 0, 0, 0);                           // R7
        step(EV_REQ, 16'h0500, 0, 0, 0, 0, 0, 0);                    // R9 idle
        for (int i = 0; i < 400; i++) begin
            int ev;
            logic [AW-1:0] a;
            ev = int'($urandom_range(1, 4));
            a = ($urandom_range(0, 2) != 0) ? m_addr : AW'($urandom_range(0, 7) * 4);
            step(ev, a, $urandom(), 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule